// File: doc/BRIEF.md
# MDIO Station-Management Master (Clause 22 and Clause 45)

This block is the management-bus master that a host uses to read and write PHY registers over a two-wire serial link. It produces the management clock (MDC) from the system clock with a parameterised divider. It also drives or releases the bidirectional data line through a separate output value, output enable and input. The surrounding pad logic resolves the line, and an external pull-up holds it high when nobody drives it.

The host presents one command at a time: a clause-select flag, a read/write flag, a 5-bit PHY address, a 21-bit register field and 16 bits of write data. A Clause 22 access is a single frame. A Clause 45 access is built as two frames without host involvement. The first is an address frame that loads the 16-bit register address into the PHY. The second is the read or write frame, sent to the same PHY and device. Completion is reported by a one-cycle done pulse, together with the captured read data and an error flag that reports a PHY which did not answer.

Top module: `mdio_master`

## Requirements
- R1: A Clause 22 frame sends 32 ones, then start bits 01, then opcode 10 for a read or 01 for a write, then the PHY address and `cmd_reg[4:0]`, each 5 bits wide and sent MSB first.
- R2: A Clause 45 access sends two frames back to back. The first uses start 00 and opcode 00, with device address `cmd_reg[20:16]` and data `cmd_reg[15:0]`. The second uses start 00, with opcode 11 for a read or 01 for a write, and carries the same PHY and device address. Each frame has its own 32-one preamble.
- R3: On write frames and on address frames, the master drives the two turnaround bits as 1 then 0, followed by 16 data bits, MSB first.
- R4: On read frames, the master releases the line for both turnaround bits and all 16 data bits. It captures the data MSB first at the end of each MDC high phase and returns it on `rd_data` with the done pulse.
- R5: On a read frame, if the second turnaround bit is sampled as 1, the master keeps the line released for 32 further MDC cycles. It then reports done with `rd_data` = 16'hFFFF and `err` = 1.
- R6: After the data phase of every frame, the line is released for one extra MDC cycle. A complete Clause 22 access therefore takes 65 MDC rising edges, and a Clause 45 access takes 130. `done` is a single-cycle pulse, and `err` is 0 for a successful access.
- R7: The MDC period is 2*MDC_HALF system clocks. With the default of 50 at a 250 MHz system clock, MDC runs at 2.5 MHz. The master changes the value it drives only while MDC is low.
- R8: A command is taken only when `busy` is low, and a command presented while busy has no effect. `busy` stays high across both frames of a Clause 45 access and falls in the same cycle that `done` is raised.
- R9: While idle, MDC is held low and the line is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command strobe, taken when not busy |
| cmd_c45 | input | 1 | 1 selects Clause 45 framing |
| cmd_rd | input | 1 | 1 for read, 0 for write |
| cmd_phy | input | 5 | PHY address |
| cmd_reg | input | 21 | Register field: [4:0] for Clause 22; [20:16] device and [15:0] register address for Clause 45 |
| cmd_wdata | input | 16 | Write data |
| busy | output | 1 | Access in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 16 | Read result, valid with done |
| err | output | 1 | PHY did not answer, valid with done |
| mdc | output | 1 | Management clock |
| mdio_out | output | 1 | Value driven on the data line |
| mdio_oe | output | 1 | Drive enable for the data line |
| mdio_in | input | 1 | Resolved data line |

## Verification
The embedded properties check, on every cycle, the rules that concern the line itself. The driven value and its enable change only while MDC is low. MDC and the enable stay quiet when idle. Read data is sampled only while the line is released. `done` lasts one cycle, `busy` ends only together with `done`, and a failed access always returns all ones. Other behaviour can only be shown by the bench's scenarios, which use a PHY model on the resolved line. These are the exact bit order and opcodes of each frame type, the automatic pairing of Clause 45 frames, the number of MDC cycles per access (including the 32-cycle recovery after a missing PHY), the round trip of written values through read-back, and a command presented while busy being ignored.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int PHY_W   = 5;
  localparam int DEV_W   = 5;
  localparam int DATA_W  = 16;
  localparam int REG_W   = 21;
  localparam int DEV_LSB = 16;
  localparam int WORD_W  = 32;   // start + op + phy + sub + ta + data

  typedef enum logic [1:0] {
    FK_ADDR  = 2'd0,
    FK_WRITE = 2'd1,
    FK_READ  = 2'd2
  } frame_kind_t;

  // {start[1:0], opcode[1:0]} for one frame
  function automatic logic [3:0] frame_code(input logic c45, input frame_kind_t k);
    logic [3:0] code;
    if (!c45) begin
      code = (k == FK_READ) ? 4'b0110 : 4'b0101;
    end else begin
      case (k)
        FK_ADDR:  code = 4'b0000;
        FK_WRITE: code = 4'b0001;
        default:  code = 4'b0011;
      endcase
    end
    return code;
  endfunction

  // Device address for Clause 45, register number for Clause 22
  function automatic logic [DEV_W-1:0] sub_addr(input logic c45, input logic [REG_W-1:0] r);
    return c45 ? r[DEV_LSB +: DEV_W] : r[DEV_W-1:0];
  endfunction

  // Serial word following the preamble, first bit at the MSB
  function automatic logic [WORD_W-1:0] frame_word(input logic c45, input frame_kind_t k,
                                                  input logic [PHY_W-1:0] phy,
                                                  input logic [DEV_W-1:0] sub,
                                                  input logic [DATA_W-1:0] data);
    return {frame_code(c45, k), phy, sub, 2'b10, data};
  endfunction
endpackage

// File: rtl/mdio_mdc_gen.sv
module mdio_mdc_gen #(
  parameter int HALF = 50
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic mdc,
  output logic fall_ev
);
  localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;
  localparam logic [CW-1:0] CNT_LAST = CW'(HALF - 1);

  logic [CW-1:0] cnt;
  logic          wrap;

  assign wrap    = run && (cnt == CNT_LAST);
  assign fall_ev = wrap && mdc;   // end of a bit: high phase is over

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (!run) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (wrap) begin
      cnt <= '0;
      mdc <= !mdc;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  AST_MDC_STOPS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(run) |-> !mdc); // R9
endmodule

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine import mdio_pkg::*; #(
  parameter int PRE_LEN  = 32,
  parameter int MISS_LEN = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  frame_kind_t       kind,
  input  logic [WORD_W-1:0] word,
  input  logic              fall_ev,
  input  logic              mdio_in,
  output logic              mdio_out,
  output logic              mdio_oe,
  output logic              frame_end,
  output logic              absent,
  output logic [DATA_W-1:0] rx_data
);
  localparam int LAST_POS = PRE_LEN + WORD_W;           // trailing released bit
  localparam int POS_W    = $clog2(LAST_POS + 1);
  localparam int MW       = (MISS_LEN > 1) ? $clog2(MISS_LEN) : 1;
  localparam logic [POS_W-1:0] P_PRE  = POS_W'(PRE_LEN);
  localparam logic [POS_W-1:0] P_TA0  = POS_W'(PRE_LEN + 14);
  localparam logic [POS_W-1:0] P_TA1  = POS_W'(PRE_LEN + 15);
  localparam logic [POS_W-1:0] P_DAT  = POS_W'(PRE_LEN + 16);
  localparam logic [POS_W-1:0] P_LAST = POS_W'(LAST_POS);
  localparam logic [MW-1:0]    M_LAST = MW'(MISS_LEN - 1);

  logic             active, miss;
  logic [POS_W-1:0] pos;
  logic [MW-1:0]    miss_cnt;

  // named internal events
  logic       is_rd, in_pre, drive_bit, ta_check, data_smp;
  logic [4:0] widx;

  assign is_rd     = (kind == FK_READ);
  assign in_pre    = (pos < P_PRE);
  assign widx      = 5'(LAST_POS - 1 - int'(pos));
  assign drive_bit = in_pre ? 1'b1 : word[widx];
  assign mdio_oe   = active && !miss && ((pos < P_TA0) || (!is_rd && (pos < P_LAST)));
  assign mdio_out  = mdio_oe && drive_bit;
  assign ta_check  = fall_ev && active && !miss && is_rd && (pos == P_TA1);
  assign data_smp  = fall_ev && active && !miss && is_rd && (pos >= P_DAT) && (pos < P_LAST);
  assign absent    = miss;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active    <= 1'b0;
      miss      <= 1'b0;
      pos       <= '0;
      miss_cnt  <= '0;
      frame_end <= 1'b0;
      rx_data   <= '0;
    end else begin
      frame_end <= 1'b0;
      if (start) begin
        active   <= 1'b1;
        miss     <= 1'b0;
        pos      <= '0;
        miss_cnt <= '0;
      end else if (fall_ev && active) begin
        if (miss) begin
          if (miss_cnt == M_LAST) begin
            active    <= 1'b0;
            frame_end <= 1'b1;
          end else begin
            miss_cnt <= miss_cnt + 1'b1;
          end
        end else if (ta_check && mdio_in) begin
          miss <= 1'b1;
        end else if (pos == P_LAST) begin
          active    <= 1'b0;
          frame_end <= 1'b1;
        end else begin
          if (data_smp) rx_data <= {rx_data[DATA_W-2:0], mdio_in};
          pos <= pos + 1'b1;
        end
      end
    end
  end

  AST_SAMPLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    (data_smp || ta_check) |-> !mdio_oe); // R4
endmodule

// File: rtl/mdio_master.sv
module mdio_master import mdio_pkg::*; #(
  parameter int MDC_HALF = 50,
  parameter int PRE_LEN  = 32,
  parameter int MISS_LEN = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic              cmd_c45,
  input  logic              cmd_rd,
  input  logic [PHY_W-1:0]  cmd_phy,
  input  logic [REG_W-1:0]  cmd_reg,
  input  logic [DATA_W-1:0] cmd_wdata,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] rd_data,
  output logic              err,
  output logic              mdc,
  output logic              mdio_out,
  output logic              mdio_oe,
  input  logic              mdio_in
);
  logic              running, start_q, c45_q, rd_q;
  frame_kind_t       kind_q;
  logic [PHY_W-1:0]  phy_q;
  logic [REG_W-1:0]  reg_q;
  logic [DATA_W-1:0] wd_q;

  // named events shared between sequencer, engine and checks
  logic              accept, fall_ev, frame_end, absent, chain, finish;
  logic [DATA_W-1:0] rx_data, payload;
  logic [WORD_W-1:0] word;

  assign busy    = running;
  assign accept  = cmd_valid && !running;
  assign chain   = frame_end && (kind_q == FK_ADDR);
  assign finish  = frame_end && (kind_q != FK_ADDR);
  assign payload = (kind_q == FK_ADDR) ? reg_q[DATA_W-1:0] : wd_q;
  assign word    = frame_word(c45_q, kind_q, phy_q, sub_addr(c45_q, reg_q), payload);

  mdio_mdc_gen #(.HALF(MDC_HALF)) u_clk (
    .clk(clk), .rst_n(rst_n), .run(running), .mdc(mdc), .fall_ev(fall_ev)
  );

  mdio_frame_engine #(.PRE_LEN(PRE_LEN), .MISS_LEN(MISS_LEN)) u_eng (
    .clk(clk), .rst_n(rst_n), .start(start_q), .kind(kind_q), .word(word),
    .fall_ev(fall_ev), .mdio_in(mdio_in), .mdio_out(mdio_out), .mdio_oe(mdio_oe),
    .frame_end(frame_end), .absent(absent), .rx_data(rx_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running <= 1'b0;
      start_q <= 1'b0;
      done    <= 1'b0;
      err     <= 1'b0;
      rd_data <= '0;
      c45_q   <= 1'b0;
      rd_q    <= 1'b0;
      kind_q  <= FK_WRITE;
      phy_q   <= '0;
      reg_q   <= '0;
      wd_q    <= '0;
    end else begin
      done    <= 1'b0;
      start_q <= 1'b0;
      if (accept) begin
        running <= 1'b1;
        start_q <= 1'b1;
        c45_q   <= cmd_c45;
        rd_q    <= cmd_rd;
        phy_q   <= cmd_phy;
        reg_q   <= cmd_reg;
        wd_q    <= cmd_wdata;
        kind_q  <= cmd_c45 ? FK_ADDR : (cmd_rd ? FK_READ : FK_WRITE);
      end else if (chain) begin
        kind_q  <= rd_q ? FK_READ : FK_WRITE;
        start_q <= 1'b1;
      end else if (finish) begin
        running <= 1'b0;
        done    <= 1'b1;
        err     <= absent;
        if (rd_q) rd_data <= absent ? '1 : rx_data;
      end
    end
  end

  AST_DRIVE_WHILE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(mdio_out) || $rose(mdio_oe)) |-> !mdc); // R7
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mdc && !mdio_oe)); // R9
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R6
  AST_MISSING_ALL_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    (done && err) |-> (rd_data == 16'hFFFF)); // R5
  AST_BUSY_ENDS_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done); // R8
endmodule

// File: tb/tb_mdio_master.sv
`timescale 1ns/1ps
module tb_mdio_master;
  import mdio_pkg::*;

  localparam int HALF   = 4;
  localparam int PHY_ID = 5;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_valid = 1'b0, cmd_c45 = 1'b0, cmd_rd = 1'b0;
  logic [4:0]  cmd_phy = '0;
  logic [20:0] cmd_reg = '0;
  logic [15:0] cmd_wdata = '0;
  logic busy, done, err, mdc, mdio_out, mdio_oe, mdio_in;
  logic [15:0] rd_data;
  logic phy_oe = 1'b0, phy_out = 1'b0, line;

  always #2 clk = ~clk;   // 250 MHz

  assign line    = mdio_oe ? mdio_out : (phy_oe ? phy_out : 1'b1);
  assign mdio_in = line;

  mdio_master #(.MDC_HALF(HALF)) dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_c45(cmd_c45), .cmd_rd(cmd_rd),
    .cmd_phy(cmd_phy), .cmd_reg(cmd_reg), .cmd_wdata(cmd_wdata), .busy(busy), .done(done),
    .rd_data(rd_data), .err(err), .mdc(mdc), .mdio_out(mdio_out), .mdio_oe(mdio_oe),
    .mdio_in(mdio_in)
  );

  int n_chk = 0, n_fail = 0;
  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] init22(input logic [4:0] r);
    return 16'hC0DE ^ {11'h0, r};
  endfunction
  function automatic logic [15:0] init45(input logic [4:0] dv, input logic [15:0] a);
    return (a * 16'd3) ^ {dv, 11'h0F3};
  endfunction

  typedef struct packed {
    logic        chk_data;
    logic [15:0] data;
    logic        err;
    logic [15:0] edges;
    logic [31:0] start_edge;
  } res_t;

  logic [29:0] exp_frm[$];   // {start, op, phy, sub, data}
  res_t        exp_res[$];
  logic [15:0] sh22 [32];
  logic [15:0] sh45 [int];
  logic [15:0] m22 [32];
  logic [15:0] m45 [int];
  logic [15:0] m_a45 = '0;
  int edge_cnt = 0, drive_viol = 0, clash = 0;

  always @(posedge mdc) edge_cnt++;

  // driver: pushes expected frames and results, then issues the command
  task automatic access(input bit c45, input bit rd, input logic [4:0] phy,
                        input logic [20:0] rg, input logic [15:0] wd);
    res_t r;
    logic [4:0] sub;
    bit present;
    int key;
    sub     = c45 ? rg[20:16] : rg[4:0];
    present = (phy == 5'(PHY_ID));
    key     = int'({11'h0, sub, rg[15:0]});
    while (busy) @(negedge clk);
    if (c45) exp_frm.push_back({4'b0000, phy, sub, rg[15:0]});
    exp_frm.push_back({c45 ? (rd ? 4'b0011 : 4'b0001) : (rd ? 4'b0110 : 4'b0101),
                       phy, sub, rd ? 16'h0000 : wd});
    r.chk_data = rd;
    r.err      = rd && !present;
    if (!rd) r.data = 16'h0;
    else if (!present) r.data = 16'hFFFF;
    else if (c45) r.data = sh45.exists(key) ? sh45[key] : init45(sub, rg[15:0]);
    else r.data = sh22[sub];
    if (!rd && present) begin
      if (c45) sh45[key] = wd;
      else sh22[sub] = wd;
    end
    r.edges      = 16'(c45 ? ((rd && !present) ? 145 : 130) : ((rd && !present) ? 80 : 65));
    r.start_edge = edge_cnt;
    exp_res.push_back(r);
    cmd_c45 = c45; cmd_rd = rd; cmd_phy = phy; cmd_reg = rg; cmd_wdata = wd;
    cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic get_bits(input int n, output logic [15:0] v);
    v = '0;
    for (int i = 0; i < n; i++) begin
      @(posedge mdc);
      v = {v[14:0], line};
    end
  endtask

  // PHY model and frame monitor
  initial begin : phy_model
    logic [15:0] st, op, pa, ra, ta, d, val;
    logic [29:0] got, exp;
    int ones, key;
    bit rd;
    forever begin
      ones = 0;
      forever begin
        @(posedge mdc);
        if (line) ones++;
        else if (ones >= 32) break;
        else ones = 0;
      end
      get_bits(1, st); st = {15'h0, st[0]};
      get_bits(2, op); get_bits(5, pa); get_bits(5, ra);
      rd = (st[1:0] == 2'b01 && op[1:0] == 2'b10) || (st[1:0] == 2'b00 && op[1:0] == 2'b11);
      d = '0;
      if (rd) begin
        if (pa[4:0] == 5'(PHY_ID)) begin
          key = int'({11'h0, ra[4:0], m_a45});
          if (st[1:0] == 2'b01) val = m22[ra[4:0]];
          else val = m45.exists(key) ? m45[key] : init45(ra[4:0], m_a45);
          @(negedge mdc);
          @(negedge mdc); #1 phy_oe = 1'b1; phy_out = 1'b0;
          for (int i = 15; i >= 0; i--) begin
            @(negedge mdc); #1 phy_out = val[i];
          end
          @(negedge mdc); #1 phy_oe = 1'b0;
        end
      end else begin
        get_bits(2, ta);
        chk(ta[1:0] == 2'b10, "R3 turnaround driven 1,0", ta[1:0], 2'b10);
        get_bits(16, d);
        if (pa[4:0] == 5'(PHY_ID)) begin
          if (st[1:0] == 2'b01) m22[ra[4:0]] = d;
          else if (op[1:0] == 2'b00) m_a45 = d;
          else m45[int'({11'h0, ra[4:0], m_a45})] = d;
        end
      end
      got = {st[1:0], op[1:0], pa[4:0], ra[4:0], d};
      if (exp_frm.size() == 0) begin
        chk(1'b0, "R8 frame with no command", got, 0);
      end else begin
        exp = exp_frm.pop_front();
        chk(got == exp, "R1/R2 frame fields", got, exp);
      end
    end
  end

  // result monitor
  initial begin : res_mon
    res_t r;
    forever begin
      @(negedge clk);
      if (rst_n && done) begin
        if (exp_res.size() == 0) begin
          chk(1'b0, "R8 done with no command", 1, 0);
        end else begin
          r = exp_res.pop_front();
          chk(err == r.err, "R5/R6 error flag", err, r.err);
          if (r.chk_data) chk(rd_data == r.data, "R4/R5 read data", rd_data, r.data);
          chk(edge_cnt - int'(r.start_edge) == int'(r.edges), "R5/R6 MDC cycles per access",
              edge_cnt - int'(r.start_edge), r.edges);
        end
      end
    end
  end

  // line discipline: drive changes only with MDC low, no contention
  initial begin : line_mon
    logic p_out, p_oe;
    p_out = 1'b0; p_oe = 1'b0;
    forever begin
      @(negedge clk);
      if (mdio_oe && (mdio_out != p_out || !p_oe) && mdc) drive_viol++;
      if (mdio_oe && phy_oe) clash++;
      p_out = mdio_out; p_oe = mdio_oe;
    end
  end

  // MDC period, R7
  initial begin : period_mon
    longint t0, t1;
    @(posedge rst_n);
    @(posedge busy);
    @(posedge mdc); t0 = $time;
    @(posedge mdc); t1 = $time;
    chk(t1 - t0 == longint'(2 * HALF * 4), "R7 MDC period", t1 - t0, 2 * HALF * 4);
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin : main
    for (int i = 0; i < 32; i++) begin
      sh22[i] = init22(5'(i));
      m22[i]  = init22(5'(i));
    end
    repeat (5) @(negedge clk);
    chk(busy == 1'b0 && done == 1'b0, "R9 reset busy/done", {busy, done}, 0);
    chk(mdc == 1'b0 && mdio_oe == 1'b0, "R9 reset line released", {mdc, mdio_oe}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(mdc == 1'b0 && mdio_oe == 1'b0 && busy == 1'b0, "R9 idle after reset",
        {mdc, mdio_oe, busy}, 0);

    access(1'b0, 1'b0, 5'(PHY_ID), 21'd3, 16'h1234);                  // R1 R3
    access(1'b0, 1'b1, 5'(PHY_ID), 21'd3, 16'h0);                     // R1 R4
    access(1'b0, 1'b1, 5'(PHY_ID), 21'd10, 16'h0);                    // R4 untouched
    access(1'b0, 1'b0, 5'(PHY_ID), 21'd31, 16'hFFFF);
    access(1'b0, 1'b1, 5'(PHY_ID), 21'd31, 16'h0);
    access(1'b1, 1'b0, 5'(PHY_ID), {5'd1, 16'h0100}, 16'hBEEF);       // R2
    access(1'b1, 1'b1, 5'(PHY_ID), {5'd1, 16'h0100}, 16'h0);          // R2 R4
    access(1'b1, 1'b1, 5'(PHY_ID), {5'd3, 16'hFFFF}, 16'h0);
    access(1'b1, 1'b0, 5'(PHY_ID), {5'd31, 16'h0000}, 16'h8001);
    access(1'b1, 1'b1, 5'(PHY_ID), {5'd31, 16'h0000}, 16'h0);
    access(1'b0, 1'b1, 5'd9, 21'd4, 16'h0);                           // R5
    access(1'b1, 1'b1, 5'd9, {5'd2, 16'h0042}, 16'h0);                // R5 after address frame

    // R8: command while busy must be ignored
    access(1'b0, 1'b0, 5'(PHY_ID), 21'd7, 16'h5A5A);
    repeat (30) @(negedge clk);
    chk(busy == 1'b1, "R8 busy during access", busy, 1);
    cmd_c45 = 1'b0; cmd_rd = 1'b0; cmd_phy = 5'(PHY_ID); cmd_reg = 21'd7; cmd_wdata = 16'h0BAD;
    cmd_valid = 1'b1;
    repeat (3) @(negedge clk);
    cmd_valid = 1'b0;
    access(1'b0, 1'b1, 5'(PHY_ID), 21'd7, 16'h0);                     // expects 5A5A

    while (busy || exp_res.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);
    chk(mdc == 1'b0 && mdio_oe == 1'b0, "R9 idle after accesses", {mdc, mdio_oe}, 0);
    chk(exp_frm.size() == 0, "R8 all expected frames seen", exp_frm.size(), 0);
    chk(drive_viol == 0, "R7 drive changes only while MDC low", drive_viol, 0);
    chk(clash == 0, "R4 no drive while PHY owns line", clash, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule